// File: doc/BRIEF.md
# Pulse Edge Timestamp Unit

This block watches one asynchronous pulse line and records the value of an internal free-running timer at both ends of every pulse. It registers the leading-edge and trailing-edge timestamps and a ready-made pulse width. It raises an interrupt flag only once per pulse, when the pulse ends. Software therefore makes a single service call per pulse and reads the width without any arithmetic of its own.

Two configuration inputs tune its use. One selects which line level counts as the pulse. The other makes each capture restart the timer. In that restart mode the trailing capture already holds the pulse length and the leading capture holds the idle time before the pulse. If a pulse ends while the previous one is still unacknowledged, an overrun flag records the loss and the newest values replace the old ones.

Top module: `pcap_edge_timer`

## Requirements
- R1: Both ends of a pulse capture the timer: the leading capture register updates on the start of a pulse and the trailing capture register updates on its end.
- R2: The line passes two synchronizer flops and an edge register, so a line change sampled at clock edge p is reflected in the outputs after clock edge p+2; before that edge the outputs still show the old state.
- R3: The interrupt flag rises only after a pulse end. The start of a pulse never sets it.
- R4: With restart mode off, the width output equals the trailing capture minus the leading capture modulo 2^TW, and it equals the pulse length in clock cycles even when the timer wraps once inside the pulse.
- R5: With restart mode on, every capture makes the timer read 1 in the next cycle. The trailing capture and the width then both equal the pulse length in cycles, and the leading capture equals the number of idle cycles since the previous pulse end.
- R6: With active_low_i = 1 a low level is the pulse and a high level is idle. With active_low_i = 0 the reverse holds.
- R7: A pulse end while the interrupt flag is set, with no clear strobe in that cycle, sets the overrun flag, and all capture registers take the newest values.
- R8: The interrupt flag and the overrun flag stay set until a one-cycle strobe on irq_clr_i clears both. The strobe leaves the capture and width registers unchanged.
- R9: A clear strobe in the same cycle as a pulse end loses to the pulse end. The interrupt flag stays set, the overrun flag is cleared rather than set, and the new captures are stored.
- R10: After reset the interrupt flag, the overrun flag, both captures and the width all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw asynchronous pulse line |
| active_low_i | input | 1 | 1: low level is the pulse |
| clr_on_cap_i | input | 1 | 1: each capture restarts the timer |
| irq_clr_i | input | 1 | One-cycle acknowledge strobe for the interrupt and overrun flags |
| lead_cap_o | output | TW | Timer value at the last pulse start |
| trail_cap_o | output | TW | Timer value at the last pulse end |
| width_o | output | TW | Length of the last complete pulse in cycles |
| irq_o | output | 1 | Pulse-complete interrupt flag |
| ovr_o | output | 1 | Overrun flag |

## Verification
The acknowledge strobe and a pulse end can fall in the same cycle. The bench provokes this by holding off the acknowledge of one pulse and then raising irq_clr_i in the exact cycle that the next trailing edge is registered. That cycle is counted from the line change through the synchronizer. The outcome is judged at the ports: the flag must still be set, overrun must read zero, and the width must be that of the newer pulse. The same structure serves the overrun case, where no strobe arrives and overrun must be set.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LEAD  = 2'd1,
        EV_TRAIL = 2'd2
    } pcap_ev_e;

    typedef struct packed {
        logic active_low;
        logic clr_on_cap;
    } pcap_cfg_t;

    function automatic pcap_ev_e pcap_classify(input logic now_lvl,
                                               input logic old_lvl,
                                               input logic primed);
        if (!primed || now_lvl == old_lvl) return EV_NONE;
        return now_lvl ? EV_LEAD : EV_TRAIL;
    endfunction

endpackage

// File: rtl/pcap_sync_edge.sv
module pcap_sync_edge
    import pcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      pin_i,
    input  logic      active_low_i,
    output pcap_ev_e  ev_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          level;
    logic          prev_q;
    logic          primed_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[LAST-1:0], pin_i};
            end
        end
    endgenerate

    assign level = chain_q[LAST] ^ active_low_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= level;
            primed_q <= 1'b1;
        end
    end

    assign ev_o = pcap_classify(level, prev_q, primed_q);

    assert_edge_is_change_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_o == EV_LEAD) |=> prev_q);

endmodule

// File: rtl/pcap_timer.sv
module pcap_timer #(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          cap_i,
    input  logic          restart_en_i,
    output logic [TW-1:0] tmr_o
);
    localparam logic [TW-1:0] ONE = TW'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i)                      tmr_o <= '0;
        else if (cap_i && restart_en_i) tmr_o <= ONE;
        else                            tmr_o <= tmr_o + ONE;
    end

endmodule

// File: rtl/pcap_capture.sv
module pcap_capture
    import pcap_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  pcap_ev_e      ev_i,
    input  logic [TW-1:0] tmr_i,
    input  logic          restart_en_i,
    input  logic          irq_clr_i,
    output logic [TW-1:0] lead_o,
    output logic [TW-1:0] trail_o,
    output logic [TW-1:0] width_o,
    output logic          irq_o,
    output logic          ovr_o
);
    logic is_trail;
    assign is_trail = (ev_i == EV_TRAIL);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lead_o  <= '0;
            trail_o <= '0;
            width_o <= '0;
        end else begin
            if (ev_i == EV_LEAD) lead_o <= tmr_i;
            if (is_trail) begin
                trail_o <= tmr_i;
                width_o <= restart_en_i ? tmr_i : TW'(tmr_i - lead_o);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_o <= 1'b0;
            ovr_o <= 1'b0;
        end else begin
            irq_o <= is_trail | (irq_o & ~irq_clr_i);
            ovr_o <= ~irq_clr_i & (ovr_o | (is_trail & irq_o));
        end
    end

    assert_irq_from_trail_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irq_o ##1 irq_o) |-> $past(ev_i) == EV_TRAIL);

    assert_lead_no_irq_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ev_i == EV_LEAD && !irq_o) |=> !irq_o);

    assert_width_mod_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_trail && !restart_en_i) |=> width_o == TW'(trail_o - lead_o));

    assert_width_direct_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_trail && restart_en_i) |=> width_o == trail_o);

    assert_overrun_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_trail && irq_o && !irq_clr_i) |=> ovr_o);

    assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !irq_clr_i) |=> irq_o);

    assert_trail_wins_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (is_trail && irq_clr_i) |=> (irq_o && !ovr_o));

endmodule

// File: rtl/pcap_edge_timer.sv
module pcap_edge_timer
    import pcap_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          pin_i,
    input  logic          active_low_i,
    input  logic          clr_on_cap_i,
    input  logic          irq_clr_i,
    output logic [TW-1:0] lead_cap_o,
    output logic [TW-1:0] trail_cap_o,
    output logic [TW-1:0] width_o,
    output logic          irq_o,
    output logic          ovr_o
);
    pcap_cfg_t     cfg;
    pcap_ev_e      ev;
    logic [TW-1:0] tmr;

    assign cfg.active_low = active_low_i;
    assign cfg.clr_on_cap = clr_on_cap_i;

    pcap_sync_edge #(.SYNC_STAGES(2)) u_sync (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .pin_i        (pin_i),
        .active_low_i (cfg.active_low),
        .ev_o         (ev)
    );

    pcap_timer #(.TW(TW)) u_tmr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .cap_i        (ev != EV_NONE),
        .restart_en_i (cfg.clr_on_cap),
        .tmr_o        (tmr)
    );

    pcap_capture #(.TW(TW)) u_cap (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ev_i         (ev),
        .tmr_i        (tmr),
        .restart_en_i (cfg.clr_on_cap),
        .irq_clr_i    (irq_clr_i),
        .lead_o       (lead_cap_o),
        .trail_o      (trail_cap_o),
        .width_o      (width_o),
        .irq_o        (irq_o),
        .ovr_o        (ovr_o)
    );

endmodule

// File: tb/pcap_edge_timer_bench.sv
module pcap_edge_timer_bench;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin = 1'b0;
    logic          al = 1'b0;
    logic          rmode = 1'b0;
    logic          iclr = 1'b0;
    logic [TW-1:0] lead, trail, width;
    logic          irq, ovr;

    pcap_edge_timer #(.TW(TW)) u_pcap_edge_timer (
        .clk_i(clk), .rst_i(rst), .pin_i(pin), .active_low_i(al),
        .clr_on_cap_i(rmode), .irq_clr_i(iclr),
        .lead_cap_o(lead), .trail_cap_o(trail), .width_o(width),
        .irq_o(irq), .ovr_o(ovr)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int hi_cnt = 0;
    int lo_cnt = 0;
    int wraps = 0;
    bit exp_irq = 0;
    bit exp_ovr = 0;
    bit skip_lead = 1;
    bit done = 0;

    always @(posedge clk) begin
        if (pin == ~al) hi_cnt <= hi_cnt + 1;
        else            lo_cnt <= lo_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int modw(input int v);
        return v & ((1 << TW) - 1);
    endfunction

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic ack();
        @(posedge clk); #1 iclr = 1'b1;
        @(posedge clk); #1 iclr = 1'b0;
        exp_irq = 0;
        exp_ovr = 0;
    endtask

    // One pulse of d cycles after g idle cycles, checks at the ports.
    task automatic run_pulse(input int d, input int g, input bit do_ack, input bit collide);
        int gap;
        int k;
        int w0;
        repeat (g) @(posedge clk);
        #1;
        gap = lo_cnt;
        lo_cnt = 0;
        hi_cnt = 0;
        pin = ~al;
        k = 0;
        repeat (d) begin
            @(posedge clk);
            k++;
            if (k == 3 && d >= 4) begin
                @(negedge clk);
                check(irq == exp_irq, "R3", "irq after lead edge", irq, exp_irq);
                if (rmode && !skip_lead)
                    check(lead == modw(gap), "R5", "lead = idle cycles", lead, modw(gap));
            end
        end
        #1 pin = al;
        w0 = width;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(width == w0, "R2", "width before sync latency", width, w0);
        if (collide) iclr = 1'b1;
        @(posedge clk);
        #1 iclr = 1'b0;
        @(negedge clk);
        exp_ovr = !collide && (exp_ovr || exp_irq);
        exp_irq = 1;
        check(irq == 1, "R2", "irq after trailing edge", irq, 1);
        check(ovr == exp_ovr, collide ? "R9" : "R7", "overrun flag", ovr, exp_ovr);
        check(width == modw(d), rmode ? "R5" : "R4", "width", width, modw(d));
        if (rmode) begin
            check(trail == modw(d), "R5", "trail = length", trail, modw(d));
        end else begin
            check(modw(trail - lead) == modw(d), "R1", "trail-lead", modw(trail - lead), modw(d));
            if (trail < lead) wraps++;
        end
        skip_lead = 0;
        if (do_ack) begin
            ack();
            @(negedge clk);
            check(irq == 0, "R8", "irq after ack", irq, 0);
            check(ovr == 0, "R8", "ovr after ack", ovr, 0);
            check(width == modw(d), "R8", "width kept by ack", width, modw(d));
        end
    endtask

    task automatic set_mode(input bit new_al, input bit new_rm);
        @(posedge clk);
        #1;
        al = new_al;
        rmode = new_rm;
        pin = new_al;
        repeat (6) @(posedge clk);
        ack();
        repeat (2) @(posedge clk);
        skip_lead = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finish");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(irq == 0, "R10", "irq at reset", irq, 0);
        check(ovr == 0, "R10", "ovr at reset", ovr, 0);
        check(lead == 0, "R10", "lead at reset", lead, 0);
        check(trail == 0, "R10", "trail at reset", trail, 0);
        check(width == 0, "R10", "width at reset", width, 0);

        // free-running, rising pulses
        run_pulse(1, 5, 1, 0);
        for (int i = 0; i < 25; i++)
            run_pulse(1 + int'($urandom % 120), 3 + int'($urandom % 60), 1, 0);
        run_pulse(200, 4, 1, 0);

        // R7 overrun, then R8 ack
        run_pulse(7, 5, 0, 0);
        run_pulse(11, 5, 0, 0);
        check(trail - lead == 11, "R7", "newest captures", int'(trail - lead), 11);
        ack();
        @(negedge clk);
        check(ovr == 0, "R8", "ovr cleared", ovr, 0);

        // R9 ack colliding with a pulse end
        run_pulse(9, 5, 0, 0);
        run_pulse(13, 5, 1, 1);

        // restart mode
        set_mode(1'b0, 1'b1);
        for (int i = 0; i < 15; i++)
            run_pulse(1 + int'($urandom % 120), 3 + int'($urandom % 60), 1, 0);

        // R6 low-active pulses, both timer modes
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 10; i++)
            run_pulse(1 + int'($urandom % 120), 3 + int'($urandom % 60), 1, 0);
        set_mode(1'b1, 1'b1);
        for (int i = 0; i < 10; i++)
            run_pulse(1 + int'($urandom % 120), 3 + int'($urandom % 60), 1, 0);
        run_pulse(6, 20, 0, 0);
        check(width == 6, "R6", "low pulse width", width, 6);

        check(wraps > 0, "R4", "timer wrap inside a pulse seen", wraps, 1);
        finish_up();
    end

endmodule